// File: doc/BRIEF.md
# Retriggerable Three-Cycle Pulse Stretcher

The block turns a level input that is asynchronous to the clock into a clean pulse aligned to the clock. The input is looked at only on rising clock edges. A trigger is the first sample of 1 after a sample of 0, or the first sample after reset. On the edge that sees a trigger, the output goes high and stays high for three clock periods. If the input goes back to 0 and then is sampled at 1 again while the output is still high, the pulse restarts and runs for three more periods counted from that later edge.

An input that stays high does not keep the pulse going. After one pulse the block holds its output low until the input has been sampled at 0, and only then does it accept a new trigger. The output is decoded from registered state bits alone (a Moore machine), so it changes only just after a clock edge. The pulse may start up to one period later than the input edge that caused it. Seven states are used: two with the output low (idle, and waiting for the input to release) and five with it high.

Top module: `pulse_stretch3`

## Requirements
- R1: When `rst` is sampled high on an edge, `pulse_out` is 0 after that edge and the machine is idle. The first sample of `trig_in`=1 after reset is a trigger, even if the input was already high during reset.
- R2: From idle, the edge that samples `trig_in`=1 drives `pulse_out` to 1 in the period right after that edge.
- R3: A single trigger with no later rise keeps `pulse_out` high for exactly three periods. This holds whether `trig_in` falls on the next sample or stays high for one or two more samples.
- R4: If `trig_in` is still sampled at 1 when the pulse ends, `pulse_out` falls after three periods and stays 0 for as long as `trig_in` keeps being sampled at 1.
- R5: After such a held input, a single sample of 0 and then a sample of 1 starts a new three-period pulse.
- R6: A rise sampled while `pulse_out` is high (0 on one edge, 1 on the next edge) keeps `pulse_out` high for the three periods that follow that later edge. This applies when the 1 is sampled at the end of the second or of the third period.
- R7: A pulse on `trig_in` that starts and ends between two rising edges has no effect on `pulse_out`.
- R8: Unless reset cuts it short, every interval in which `pulse_out` is high lasts at least three consecutive periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes happen on its rising edge |
| rst | input | 1 | Synchronous reset, active high, forces the idle state |
| trig_in | input | 1 | Trigger level; may be asynchronous to `clk`, but is only used as sampled on rising edges |
| pulse_out | output | 1 | Stretched pulse, high for three or more whole periods per trigger |

## Verification
The checker takes `trig_in` as it is sampled on rising edges. It assumes that this sampled value meets setup and hold, so every edge sees a clean 0 or 1. The checker also treats reset as the only thing that can shorten a pulse. To stay inside these assumptions, the stimulus changes `trig_in` only near the falling edge, or in short glitches between edges, and it never moves the input close to a rising edge. Reset is raised and dropped on falling edges only. The run-length check is skipped for a pulse that reset cut short on purpose.

// File: rtl/pulse_stretch3_pkg.sv
package pulse_stretch3_pkg;

    // Number of state bits; fixed by the seven-state machine.
    localparam int STATE_W = 3;
    // Number of periods a fresh trigger keeps the output high.
    localparam int PULSE_LEN = 3;

    // State encoding. Output is high exactly when bit 0 or bit 1 is set,
    // so both low-output states keep those two bits clear.
    // FRESHn : pulse period n, input last sampled 1 (not armed for retrigger)
    // ARMEDn : pulse period n, input last sampled 0 (armed for retrigger)
    typedef enum logic [STATE_W-1:0] {
        ST_IDLE   = 3'b000,
        ST_HOLD   = 3'b100,
        ST_FRESH1 = 3'b001,
        ST_FRESH2 = 3'b010,
        ST_FRESH3 = 3'b011,
        ST_ARMED2 = 3'b110,
        ST_ARMED3 = 3'b101
    } stretch_state_e;

    // Next state as a function of present state and sampled input.
    // Any encoding outside the seven legal ones goes back to idle.
    function automatic logic [STATE_W-1:0] next_state(
        input logic [STATE_W-1:0] cur,
        input logic               smp
    );
        logic [STATE_W-1:0] nxt;
        case (cur)
            ST_IDLE:   nxt = smp ? ST_FRESH1 : ST_IDLE;
            ST_HOLD:   nxt = smp ? ST_HOLD   : ST_IDLE;
            ST_FRESH1: nxt = smp ? ST_FRESH2 : ST_ARMED2;
            ST_FRESH2: nxt = smp ? ST_FRESH3 : ST_ARMED3;
            ST_FRESH3: nxt = smp ? ST_HOLD   : ST_IDLE;
            ST_ARMED2: nxt = smp ? ST_FRESH1 : ST_ARMED3;
            ST_ARMED3: nxt = smp ? ST_FRESH1 : ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
        return nxt;
    endfunction

    // Moore output decode.
    function automatic logic output_high(input logic [STATE_W-1:0] cur);
        return cur[0] | cur[1];
    endfunction

endpackage

// File: rtl/pulse_stretch3_next.sv
module pulse_stretch3_next
    import pulse_stretch3_pkg::*;
(
    input  logic [STATE_W-1:0] cur_state,
    input  logic               smp_in,
    output logic [STATE_W-1:0] nxt_state
);

    always_comb begin
        nxt_state = next_state(cur_state, smp_in);
    end

endmodule

// File: rtl/pulse_stretch3_reg.sv
module pulse_stretch3_reg
    import pulse_stretch3_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [STATE_W-1:0] nxt_state,
    output logic [STATE_W-1:0] cur_state
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_state <= ST_IDLE;
        end else begin
            cur_state <= nxt_state;
        end
    end

endmodule

// File: rtl/pulse_stretch3_dec.sv
module pulse_stretch3_dec
    import pulse_stretch3_pkg::*;
(
    input  logic [STATE_W-1:0] cur_state,
    output logic               out_high
);

    always_comb begin
        out_high = output_high(cur_state);
    end

endmodule

// File: rtl/pulse_stretch3.sv
module pulse_stretch3
    import pulse_stretch3_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trig_in,
    output logic pulse_out
);

    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] state_d;

    pulse_stretch3_next u_next (
        .cur_state (state_q),
        .smp_in    (trig_in),
        .nxt_state (state_d)
    );

    pulse_stretch3_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .nxt_state (state_d),
        .cur_state (state_q)
    );

    pulse_stretch3_dec u_dec (
        .cur_state (state_q),
        .out_high  (pulse_out)
    );

endmodule

// File: rtl/pulse_stretch3_chk.sv
module pulse_stretch3_chk
    import pulse_stretch3_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic trig_in,
    input logic pulse_out
);

    localparam int RUN_W = $clog2(PULSE_LEN + 1);

    logic             smp_prev;
    logic             out_prev;
    logic [RUN_W-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_prev <= 1'b0;
            out_prev <= 1'b0;
            run_len  <= '0;
        end else begin
            smp_prev <= trig_in;
            out_prev <= pulse_out;
            if (!pulse_out) begin
                run_len <= '0;
            end else if (run_len != RUN_W'(PULSE_LEN)) begin
                run_len <= run_len + 1'b1;
            end
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !pulse_out);

    // R2
    start_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_in && !smp_prev && !pulse_out) |=> pulse_out);

    // R6
    extend_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_in && !smp_prev && pulse_out) |=> pulse_out);

    // R4
    held_stays_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!pulse_out && smp_prev && trig_in) |=> !pulse_out);

    // R8
    min_width_chk: assert property (@(posedge clk) disable iff (rst)
        (out_prev && !pulse_out) |-> (run_len == RUN_W'(PULSE_LEN)));

endmodule

bind pulse_stretch3 pulse_stretch3_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .trig_in   (trig_in),
    .pulse_out (pulse_out)
);

// File: tb/sim_pulse_stretch3.sv
module sim_pulse_stretch3;

    localparam int CLK_PERIOD = 10;

    logic clk     = 1'b0;
    logic rst     = 1'b1;
    logic trig_in = 1'b0;
    logic pulse_out;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pulse_stretch3 u0 (
        .clk       (clk),
        .rst       (rst),
        .trig_in   (trig_in),
        .pulse_out (pulse_out)
    );

    bit    exp_q[$];
    string tag_q[$];
    int    n_run  = 0;
    int    n_fail = 0;
    int    mdl_left  = 0;
    bit    mdl_prev  = 1'b0;
    bit    finished  = 1'b0;

    task automatic push_exp(input bit e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    // Reference model from the requirements: a sampled 0->1 restarts
    // a three-period count, otherwise the count runs down.
    task automatic model_sample(input bit xv, input string t);
        if (xv && !mdl_prev) mdl_left = 3;
        else if (mdl_left > 0) mdl_left = mdl_left - 1;
        mdl_prev = xv;
        push_exp(mdl_left > 0, t);
    endtask

    task automatic step(input bit xv, input string t);
        @(negedge clk);
        rst     = 1'b0;
        trig_in = xv;
        model_sample(xv, t);
    endtask

    task automatic do_reset(input bit xv, input string t);
        @(negedge clk);
        rst      = 1'b1;
        trig_in  = xv;
        mdl_left = 0;
        mdl_prev = 1'b0;
        push_exp(1'b0, t);
    endtask

    // Input pulse entirely between two rising edges: sampled as 0.
    task automatic glitch(input string t);
        @(negedge clk);
        rst     = 1'b0;
        trig_in = 1'b0;
        model_sample(1'b0, t);
        #(CLK_PERIOD / 8) trig_in = 1'b1;
        #(CLK_PERIOD / 8) trig_in = 1'b0;
    endtask

    // Monitor: compares just after each rising edge and tracks run length.
    initial begin
        int  run = 0;
        bit  e;
        string t;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_run++;
                if (pulse_out !== e) begin
                    n_fail++;
                    $display("FAIL %s: pulse_out=%0b expected %0b", t, pulse_out, e);
                end
            end
            if (rst) begin
                run = 0;
            end else if (pulse_out === 1'b1) begin
                run++;
            end else begin
                if (run > 0) begin
                    n_run++;  // R8 width check
                    if (run < 3) begin
                        n_fail++;
                        $display("FAIL R8: high run=%0d expected >= 3", run);
                    end
                end
                run = 0;
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        push_exp(1'b0, "R1");
        repeat (2) step(1'b0, "R1");

        // R2 / R3: single trigger, input drops at once
        step(1'b1, "R2");
        repeat (4) step(1'b0, "R3");

        // R3: input stays high two samples, still three periods
        step(1'b1, "R2");
        step(1'b1, "R3");
        repeat (3) step(1'b0, "R3");

        // R6: rise sampled at end of second period
        step(1'b1, "R2");
        step(1'b0, "R6");
        step(1'b1, "R6");
        repeat (4) step(1'b0, "R6");

        // R6: rise sampled at end of third period
        step(1'b1, "R2");
        step(1'b0, "R6");
        step(1'b0, "R6");
        step(1'b1, "R6");
        repeat (4) step(1'b0, "R6");

        // R6 then R4: retrigger and hold high
        step(1'b1, "R2");
        step(1'b0, "R6");
        repeat (6) step(1'b1, "R4");
        step(1'b0, "R4");

        // R4: long hold from idle
        repeat (10) step(1'b1, "R4");
        // R5: one low sample re-arms
        step(1'b0, "R5");
        step(1'b1, "R5");
        repeat (4) step(1'b0, "R5");

        // R2: new trigger one sample after a pulse ends
        step(1'b1, "R2");
        repeat (3) step(1'b0, "R3");
        step(1'b1, "R2");
        repeat (4) step(1'b0, "R3");

        // R7: glitches between edges are unseen
        repeat (4) glitch("R7");
        step(1'b0, "R7");

        // R1: reset in mid-pulse with the input held high
        step(1'b1, "R2");
        do_reset(1'b1, "R1");
        step(1'b1, "R1");
        step(1'b1, "R1");
        repeat (4) step(1'b0, "R1");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule